// File: doc/BRIEF.md
# Memory-Device Data Termination Gate

This block sits on the device side of a low-power DRAM and decides, cycle by cycle, whether the data-line termination resistor is switched in. It holds one mode register that software programs through the mode-register write path. The low two bits of that register give the termination strength, and any nonzero strength arms the feature. Bit 2 says whether termination may stay on while the device is in power-down. With a two-rank board sharing one termination pin, this lets the idle rank keep terminating for its active neighbour.

Once termination is armed, the external termination pin switches it on and off during idle and write cycles. A read, the low-power states, and all training and calibration states force it off whatever the pin does. The decision is registered on the device clock. The stored register byte is returned on a readback output, and the strength field is passed on separately to the analog side.

Top module: `dev_term_ctrl`

## Requirements
- R1: While rst_ni is low, term_o, strength_o and mr_o are all zero, so termination is disabled after reset.
- R2: A write with mrw_en_i high and mrw_addr_i equal to 11 stores mrw_data_i. The byte appears on mr_o one cycle later. A write to any other address leaves mr_o unchanged.
- R3: While the strength field mr_o[1:0] is zero, term_o stays low whatever odt_i and op_i do.
- R4: With a nonzero strength and op_i at idle (0) or write (1), term_o equals the odt_i value of the previous cycle.
- R5: With op_i at read (2), term_o is low in the following cycle even when odt_i is high.
- R6: With op_i at power-down (3), term_o in the following cycle equals odt_i AND mr_o[2], given a nonzero strength.
- R7: The states self-refresh (4), deep power-down (5), CA calibration (6), ZQ calibration (7), write leveling (8) and every unassigned code (9 to 15) force term_o low in the following cycle.
- R8: strength_o always equals mr_o[1:0].
- R9: term_o is registered. It depends only on odt_i and op_i as sampled one cycle earlier, and on the mode register contents that were in place before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mrw_en_i | input | 1 | Mode-register write strobe |
| mrw_addr_i | input | 8 | Mode-register write address |
| mrw_data_i | input | 8 | Mode-register write data |
| odt_i | input | 1 | External termination pin |
| op_i | input | 4 | Current operation code from the command decoder |
| term_o | output | 1 | Termination enable |
| strength_o | output | 2 | Encoded termination strength for the analog side |
| mr_o | output | 8 | Readback of the termination mode register |

## Verification
The properties assume that op_i carries one code per cycle from the command decoder and that a mode write lands in a single cycle. They relate each cycle's output to the previous cycle's pin, state and stored register, so they make no assumption about how the pin is sequenced against commands. The stimulus draws op_i from the full 4-bit range, including unassigned codes. It toggles the pin independently of the state and mixes writes to address 11 with writes to other addresses, so every override path is reached with the pin both high and low. Directed cases cover a zero strength with the pin high, a read with the pin held high, and power-down under both settings of the policy bit.

// File: rtl/dev_term_pkg.sv
package dev_term_pkg;
  localparam int unsigned STR_W = 2;
  localparam int unsigned PD_BIT = STR_W;

  typedef enum logic [3:0] {
    OP_IDLE  = 4'd0,
    OP_WRITE = 4'd1,
    OP_READ  = 4'd2,
    OP_PDOWN = 4'd3,
    OP_SREF  = 4'd4,
    OP_DPD   = 4'd5,
    OP_CACAL = 4'd6,
    OP_ZQCAL = 4'd7,
    OP_WLEV  = 4'd8
  } op_e;
endpackage

// File: rtl/dev_term_mr.sv
module dev_term_mr #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MR_ADDR = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] mr_o
);
  localparam logic [ADDR_W-1:0] HIT = ADDR_W'(MR_ADDR);

  logic hit;
  assign hit = we_i && (addr_i == HIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mr_o <= '0;
    else if (hit) mr_o <= data_i;
  end
endmodule

// File: rtl/dev_term_policy.sv
module dev_term_policy
  import dev_term_pkg::*;
#(
  parameter int unsigned OP_W = 4
) (
  input  logic [STR_W-1:0] strength_i,
  input  logic             pd_keep_i,
  input  logic             odt_i,
  input  logic [OP_W-1:0]  op_i,
  output logic             term_d_o
);
  logic armed, allow;

  assign armed = |strength_i;

  always_comb begin
    unique case (op_i)
      OP_IDLE, OP_WRITE: allow = 1'b1;
      OP_PDOWN:          allow = pd_keep_i;
      default:           allow = 1'b0;  // read, low-power, training, unassigned
    endcase
  end

  assign term_d_o = armed & odt_i & allow;
endmodule

// File: rtl/dev_term_out.sv
module dev_term_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic term_d_i,
  output logic term_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) term_o <= 1'b0;
    else         term_o <= term_d_i;
  end
endmodule

// File: rtl/dev_term_ctrl.sv
module dev_term_ctrl
  import dev_term_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OP_W    = 4,
  parameter int unsigned MR_ADDR = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrw_en_i,
  input  logic [ADDR_W-1:0] mrw_addr_i,
  input  logic [DATA_W-1:0] mrw_data_i,
  input  logic              odt_i,
  input  logic [OP_W-1:0]   op_i,
  output logic              term_o,
  output logic [STR_W-1:0]  strength_o,
  output logic [DATA_W-1:0] mr_o
);
  logic term_d;

  dev_term_mr #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MR_ADDR(MR_ADDR)
  ) u_mr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (mrw_en_i),
    .addr_i(mrw_addr_i),
    .data_i(mrw_data_i),
    .mr_o  (mr_o)
  );

  assign strength_o = mr_o[STR_W-1:0];

  dev_term_policy #(.OP_W(OP_W)) u_pol (
    .strength_i(strength_o),
    .pd_keep_i (mr_o[PD_BIT]),
    .odt_i     (odt_i),
    .op_i      (op_i),
    .term_d_o  (term_d)
  );

  dev_term_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .term_d_i(term_d),
    .term_o  (term_o)
  );
endmodule

// File: rtl/dev_term_chk.sv
module dev_term_chk #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OP_W    = 4,
  parameter int unsigned MR_ADDR = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mrw_en_i,
  input logic [ADDR_W-1:0] mrw_addr_i,
  input logic [DATA_W-1:0] mrw_data_i,
  input logic              odt_i,
  input logic [OP_W-1:0]   op_i,
  input logic              term_o,
  input logic [1:0]        strength_o,
  input logic [DATA_W-1:0] mr_o
);
  localparam logic [ADDR_W-1:0] HIT = ADDR_W'(MR_ADDR);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (term_o == 1'b0 && mr_o == '0);
    end
  end

  assert_mr_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrw_en_i && mrw_addr_i == HIT) |=> (mr_o == $past(mrw_data_i)));

  assert_mr_ignore_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mrw_en_i && mrw_addr_i == HIT) |=> $stable(mr_o));

  assert_disabled_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strength_o == 2'd0) |=> !term_o);

  assert_pin_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strength_o != 2'd0 && op_i <= OP_W'(1)) |=> (term_o == $past(odt_i)));

  assert_read_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_W'(2)) |=> !term_o);

  assert_pdown_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_W'(3) && strength_o != 2'd0)
      |=> (term_o == ($past(odt_i) && $past(mr_o[2]))));

  assert_override_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= OP_W'(4)) |=> !term_o);

  always_comb begin
    assert_strength_R8: assert (strength_o == mr_o[1:0]);
  end

  assert_no_pin_no_term_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !odt_i |=> !term_o);
endmodule

bind dev_term_ctrl dev_term_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .OP_W   (OP_W),
  .MR_ADDR(MR_ADDR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mrw_en_i  (mrw_en_i),
  .mrw_addr_i(mrw_addr_i),
  .mrw_data_i(mrw_data_i),
  .odt_i     (odt_i),
  .op_i      (op_i),
  .term_o    (term_o),
  .strength_o(strength_o),
  .mr_o      (mr_o)
);

// File: tb/sim_dev_term_ctrl.sv
`timescale 1ns/1ps
module sim_dev_term_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] data = '0;
  logic       odt = 1'b0;
  logic [3:0] op = '0;
  logic       term_o;
  logic [1:0] strength_o;
  logic [7:0] mr_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] mr_m = '0;

  always #2.5 clk = ~clk;

  dev_term_ctrl u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mrw_en_i  (we),
    .mrw_addr_i(addr),
    .mrw_data_i(data),
    .odt_i     (odt),
    .op_i      (op),
    .term_o    (term_o),
    .strength_o(strength_o),
    .mr_o      (mr_o)
  );

  function automatic logic ref_term(logic [7:0] m, logic p, logic [3:0] s);
    if (m[1:0] == 2'd0) return 1'b0;
    case (s)
      4'd0, 4'd1: return p;
      4'd3:       return p & m[2];
      default:    return 1'b0;
    endcase
  endfunction

  function automatic string ref_tag(logic [7:0] m, logic [3:0] s);
    if (m[1:0] == 2'd0) return "R3";
    case (s)
      4'd0, 4'd1: return "R4";
      4'd2:       return "R5";
      4'd3:       return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // drive at negedge, output sampled one negedge after the capturing posedge
  task automatic apply(input logic p, input logic [3:0] s, input logic w,
                       input logic [7:0] a, input logic [7:0] d);
    logic  e;
    string t;
    odt = p; op = s; we = w; addr = a; data = d;
    e = ref_term(mr_m, p, s);
    t = ref_tag(mr_m, s);
    @(posedge clk);
    if (w && a == 8'd11) mr_m = d;
    @(negedge clk);
    chk(term_o === e, {t, "/R9 term"}, {7'd0, term_o}, {7'd0, e});
    chk(strength_o === mr_m[1:0], "R8 strength", {6'd0, strength_o}, {6'd0, mr_m[1:0]});
    chk(mr_o === mr_m, "R2 readback", mr_o, mr_m);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    odt = 1'b1; op = 4'd1;
    repeat (3) @(negedge clk);
    chk(term_o === 1'b0, "R1 term", {7'd0, term_o}, 8'd0);
    chk(strength_o === 2'd0, "R1 strength", {6'd0, strength_o}, 8'd0);
    chk(mr_o === 8'd0, "R1 mr", mr_o, 8'd0);
    rst_n = 1'b1;

    // R3: pin high during writes with strength zero
    apply(1'b1, 4'd1, 1'b0, 8'd0, 8'd0);
    apply(1'b1, 4'd0, 1'b0, 8'd0, 8'd0);
    // R2: write to wrong address is ignored
    apply(1'b1, 4'd1, 1'b1, 8'd10, 8'hFF);
    apply(1'b1, 4'd1, 1'b0, 8'd0, 8'd0);
    // arm, strength 2, no power-down keep
    apply(1'b1, 4'd1, 1'b1, 8'd11, 8'h02);
    apply(1'b1, 4'd1, 1'b0, 8'd0, 8'd0);     // R4 on
    apply(1'b0, 4'd1, 1'b0, 8'd0, 8'd0);     // R4 off
    apply(1'b1, 4'd2, 1'b0, 8'd0, 8'd0);     // R5 read with pin high
    apply(1'b1, 4'd3, 1'b0, 8'd0, 8'd0);     // R6 keep=0
    apply(1'b1, 4'd3, 1'b1, 8'd11, 8'h07);   // R6 keep=0 still (write lands after)
    apply(1'b1, 4'd3, 1'b0, 8'd0, 8'd0);     // R6 keep=1
    for (int s = 4; s < 16; s++) apply(1'b1, 4'(s), 1'b0, 8'd0, 8'd0);  // R7
    apply(1'b1, 4'd0, 1'b1, 8'd11, 8'hA4);   // disable via strength 0, reserved bits kept
    apply(1'b1, 4'd0, 1'b0, 8'd0, 8'd0);     // R3

    for (int i = 0; i < 3000; i++) begin
      logic       w;
      logic [7:0] a;
      w = ($urandom % 8) == 0;
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'd11;
      apply(1'($urandom), 4'($urandom), w, a, 8'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule